// File: doc/BRIEF.md
# Host Byte FIFO with Command Capture

This block sits in the data path of a storage bus controller. It gives the host a single byte-wide write port and a byte-wide read port. While the controller is collecting a command, every byte the host writes goes into a separate command buffer, which the sequencer reads by index. At all other times, written bytes go into a transfer buffer that the host drains through the read port. The block also keeps a signed count of data still pending.

The controller can load a two-byte status response into the transfer buffer in a single cycle. The first byte is the status and the second is zero. During a data-out bus phase, a host read returns zero and removes nothing from the buffer. Each time the transfer buffer empties, both pointers fall back to slot zero, so the next burst can use the whole storage again.

Both host ports use valid/ready handshakes. A write is accepted when `wr_valid` and `wr_ready` are both high. `wr_ready` goes low only in a cycle where `rsp_load` is high. A read is accepted when `rd_valid` and `rd_ready` are both high. `rd_ready` goes low when `rsp_load` is high or when a write is offered in the same cycle, so the two host ports never act in the same cycle. An accepted read updates `rd_data` at the clock edge that accepts it, and `rd_data_vld` is high for the following cycle. A write that finds no room is still accepted, but its byte is dropped and an overrun flag is raised.

Top module: `xfer_byte_fifo`

## Requirements
- R1: After reset, `wr_ptr`, `rd_ptr`, `data_count`, `cmd_len`, `cmd_active`, `rd_data`, `rd_data_vld`, `ovf_xfer` and `ovf_cmd` are all zero.
- R2: `wr_ready` is the inverse of `rsp_load`. `rd_ready` is high only when both `rsp_load` and `wr_valid` are low.
- R3: Outside command mode, an accepted write with `wr_ptr` equal to DEPTH-1 is dropped. The pointers and `data_count` do not change, and `ovf_xfer` is high for exactly the next cycle. Any other such write stores the byte, advances `wr_ptr` and adds one to `data_count`.
- R4: An accepted read with `phase_dout` low and `rd_ptr` below `wr_ptr` returns the oldest byte in write order. It also advances `rd_ptr`, subtracts one from `data_count`, and raises `rd_data_vld` for the next cycle.
- R5: When an accepted read leaves `rd_ptr` equal to `wr_ptr`, both pointers become zero at that same edge.
- R6: An accepted read with `phase_dout` high sets `rd_data` to 0x00 and leaves the pointers and `data_count` unchanged.
- R7: An accepted read of an empty buffer with `phase_dout` low leaves `rd_data` at its previous value.
- R8: While `cmd_active` is high, an accepted write with `cmd_len` below CMD_DEPTH stores the byte at index `cmd_len` and increments `cmd_len`. `wr_ptr`, `rd_ptr` and `data_count` stay unchanged. `cmd_byte` shows the entry selected by `cmd_idx`.
- R9: While `cmd_active` is high, an accepted write with `cmd_len` equal to CMD_DEPTH is dropped. `cmd_len` stays unchanged and `ovf_cmd` is high for exactly the next cycle.
- R10: `cmd_arm` sets `cmd_active` and clears `cmd_len`, both pointers and `data_count`. `cmd_consume` clears `cmd_active`, `cmd_len` and `data_count`. If both strobes are high together, `cmd_consume` wins for the command state.
- R11: `rsp_load` writes `rsp_status` into slot 0 and 0x00 into slot 1. It sets `rd_ptr` to 0, `wr_ptr` to 2 and `data_count` to 2, and overrides any other action on the transfer buffer in that cycle. Two reads then return the status byte, then 0x00, and leave both pointers at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host offers a write byte |
| wr_ready | output | 1 | Write accepted this cycle |
| wr_data | input | 8 | Host write byte |
| rd_valid | input | 1 | Host requests a read |
| rd_ready | output | 1 | Read accepted this cycle |
| rd_data | output | 8 | Read-result register |
| rd_data_vld | output | 1 | High the cycle after an accepted read |
| cmd_arm | input | 1 | Enter command collection (pulse) |
| cmd_consume | input | 1 | Command taken; leave command collection (pulse) |
| cmd_active | output | 1 | Command collection mode |
| cmd_len | output | $clog2(CMD_DEPTH+1) | Bytes held in the command buffer |
| cmd_idx | input | $clog2(CMD_DEPTH) | Command buffer read index |
| cmd_byte | output | 8 | Command byte at `cmd_idx` |
| phase_dout | input | 1 | Bus is in the data-out phase |
| rsp_load | input | 1 | Load the two-byte status response (pulse) |
| rsp_status | input | 8 | Status byte for the response |
| wr_ptr | output | $clog2(DEPTH) | Transfer buffer write pointer |
| rd_ptr | output | $clog2(DEPTH) | Transfer buffer read pointer |
| data_count | output | $clog2(DEPTH)+2 | Signed pending-data count |
| ovf_xfer | output | 1 | Transfer buffer write overrun (one-cycle pulse) |
| ovf_cmd | output | 1 | Command buffer write overrun (one-cycle pulse) |

## Verification
A pointer that fails to return to zero after draining shows up on `wr_ptr` and `rd_ptr` in the cycle after the last read. Within about DEPTH further writes, it also shows up as an overrun that comes too early. A wrong route for a write, into the command buffer or the transfer buffer, shows the cycle after the write, as movement in `cmd_len` or in `wr_ptr` that should not happen. An error in stored order or content stays hidden until the byte is popped; it then appears on `rd_data` at the edge that accepts that read. Counting errors appear on `data_count` at every edge, so the checks compare it after each step.

// File: rtl/xfb_pkg.sv
package xfb_pkg;
  // Result of an accepted host read
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_ZERO = 2'd1,
    RD_POP  = 2'd2,
    RD_HOLD = 2'd3
  } xfb_rd_kind_e;

  localparam logic [7:0] RSP_TAIL = 8'h00;
endpackage

// File: rtl/xfb_ring.sv
module xfb_ring #(
  parameter int DEPTH = 16,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          rsp_load,
  input  logic [7:0]    rsp_byte,
  input  logic          push,
  input  logic [7:0]    wdata,
  input  logic          pop,
  input  logic          rd_evt,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] rptr,
  output logic [7:0]    head
);
  import xfb_pkg::*;

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wp_n, rp_n;

  // storage: the response load owns slots 0 and 1 in its cycle
  always_ff @(posedge clk) begin
    if (rsp_load) begin
      mem[0] <= rsp_byte;
      mem[1] <= RSP_TAIL;
    end else if (push && !clr) begin
      mem[wptr] <= wdata;
    end
  end

  always_comb begin
    wp_n = wptr;
    rp_n = rptr;
    if (rsp_load) begin
      wp_n = PW'(2);
      rp_n = '0;
    end else if (clr) begin
      wp_n = '0;
      rp_n = '0;
    end else begin
      if (push) wp_n = wptr + PW'(1);
      if (pop)  rp_n = rptr + PW'(1);
      // drained: rewind both pointers
      if (rd_evt && (rp_n == wp_n)) begin
        wp_n = '0;
        rp_n = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      wptr <= wp_n;
      rptr <= rp_n;
    end
  end

  assign head = mem[rptr];
endmodule

// File: rtl/xfb_cmd_capture.sv
module xfb_cmd_capture #(
  parameter int CMD_DEPTH = 16,
  parameter int CLW       = $clog2(CMD_DEPTH + 1),
  parameter int CIW       = $clog2(CMD_DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           arm,
  input  logic           consume,
  input  logic           wr,
  input  logic [7:0]     wdata,
  input  logic [CIW-1:0] idx,
  output logic           active,
  output logic [CLW-1:0] len,
  output logic [7:0]     byte_out,
  output logic           drop
);
  logic [7:0] cbuf [CMD_DEPTH];
  logic       room;

  assign room = (len < CLW'(CMD_DEPTH));
  assign drop = wr && active && !room && !consume && !arm;

  always_ff @(posedge clk) begin
    if (wr && active && room && !consume && !arm)
      cbuf[len[CIW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      len    <= '0;
    end else if (consume) begin
      active <= 1'b0;
      len    <= '0;
    end else if (arm) begin
      active <= 1'b1;
      len    <= '0;
    end else if (wr && active && room) begin
      len <= len + CLW'(1);
    end
  end

  assign byte_out = cbuf[idx];
endmodule

// File: rtl/xfer_byte_fifo.sv
module xfer_byte_fifo #(
  parameter int DEPTH     = 16,
  parameter int CMD_DEPTH = 16,
  localparam int PW    = $clog2(DEPTH),
  localparam int CLW   = $clog2(CMD_DEPTH + 1),
  localparam int CIW   = $clog2(CMD_DEPTH),
  localparam int CNT_W = PW + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  input  logic             rd_valid,
  output logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             rd_data_vld,
  input  logic             cmd_arm,
  input  logic             cmd_consume,
  output logic             cmd_active,
  output logic [CLW-1:0]   cmd_len,
  input  logic [CIW-1:0]   cmd_idx,
  output logic [7:0]       cmd_byte,
  input  logic             phase_dout,
  input  logic             rsp_load,
  input  logic [7:0]       rsp_status,
  output logic [PW-1:0]    wr_ptr,
  output logic [PW-1:0]    rd_ptr,
  output logic [CNT_W-1:0] data_count,
  output logic             ovf_xfer,
  output logic             ovf_cmd
);
  import xfb_pkg::*;

  logic         wr_fire, rd_fire, x_wr, x_full, push, pop, drop_x, drop_c;
  logic [7:0]   head;
  xfb_rd_kind_e rd_kind;

  // host port arbitration: response load first, then write, then read
  assign wr_ready = !rsp_load;
  assign rd_ready = !rsp_load && !wr_valid;
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_fire  = rd_valid && rd_ready;

  assign x_wr   = wr_fire && !cmd_active;
  assign x_full = (wr_ptr == PW'(DEPTH - 1));
  assign push   = x_wr && !x_full;
  assign drop_x = x_wr && x_full && !cmd_arm;

  always_comb begin
    if (!rd_fire)                 rd_kind = RD_NONE;
    else if (phase_dout)          rd_kind = RD_ZERO;
    else if (rd_ptr < wr_ptr)     rd_kind = RD_POP;
    else                          rd_kind = RD_HOLD;
  end
  assign pop = (rd_kind == RD_POP);

  xfb_ring #(.DEPTH(DEPTH), .PW(PW)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cmd_arm),
    .rsp_load (rsp_load),
    .rsp_byte (rsp_status),
    .push     (push),
    .wdata    (wr_data),
    .pop      (pop),
    .rd_evt   (rd_fire),
    .wptr     (wr_ptr),
    .rptr     (rd_ptr),
    .head     (head)
  );

  xfb_cmd_capture #(.CMD_DEPTH(CMD_DEPTH), .CLW(CLW), .CIW(CIW)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (cmd_arm),
    .consume  (cmd_consume),
    .wr       (wr_fire),
    .wdata    (wr_data),
    .idx      (cmd_idx),
    .active   (cmd_active),
    .len      (cmd_len),
    .byte_out (cmd_byte),
    .drop     (drop_c)
  );

  // read-result register and pending-data count
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data     <= '0;
      rd_data_vld <= 1'b0;
      data_count  <= '0;
      ovf_xfer    <= 1'b0;
      ovf_cmd     <= 1'b0;
    end else begin
      rd_data_vld <= rd_fire;
      ovf_xfer    <= drop_x;
      ovf_cmd     <= drop_c;
      case (rd_kind)
        RD_ZERO: rd_data <= '0;
        RD_POP:  rd_data <= head;
        default: rd_data <= rd_data;
      endcase
      if (rsp_load)                 data_count <= CNT_W'(2);
      else if (cmd_arm || cmd_consume) data_count <= '0;
      else if (push)                data_count <= data_count + CNT_W'(1);
      else if (pop)                 data_count <= data_count - CNT_W'(1);
    end
  end
endmodule

// File: rtl/xfer_byte_fifo_chk.sv
module xfer_byte_fifo_chk #(
  parameter int DEPTH     = 16,
  parameter int CMD_DEPTH = 16,
  parameter int PW        = 4,
  parameter int CLW       = 5,
  parameter int CNT_W     = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [7:0]       rd_data,
  input logic             cmd_arm,
  input logic             cmd_consume,
  input logic             cmd_active,
  input logic [CLW-1:0]   cmd_len,
  input logic             phase_dout,
  input logic             rsp_load,
  input logic [PW-1:0]    wr_ptr,
  input logic [PW-1:0]    rd_ptr,
  input logic [CNT_W-1:0] data_count,
  input logic             ovf_xfer,
  input logic             ovf_cmd
);
  // R3
  xfer_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !cmd_active && !cmd_arm && wr_ptr == PW'(DEPTH - 1))
      |=> (ovf_xfer && $stable(wr_ptr) && $stable(data_count)));

  // R5
  drain_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ptr == wr_ptr) |-> (rd_ptr == '0));

  // R6
  dout_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && phase_dout && !cmd_arm)
      |=> (rd_data == 8'h00 && $stable(rd_ptr) && $stable(data_count)));

  // R8
  cmd_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && cmd_active && !cmd_arm && !cmd_consume)
      |=> ($stable(wr_ptr) && $stable(rd_ptr) && $stable(data_count)));

  // R9
  cmd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && cmd_active && !cmd_arm && !cmd_consume
     && cmd_len == CLW'(CMD_DEPTH))
      |=> (ovf_cmd && cmd_len == CLW'(CMD_DEPTH)));

  // R11
  rsp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_load |=> (wr_ptr == PW'(2) && rd_ptr == '0 && data_count == CNT_W'(2)));
endmodule

bind xfer_byte_fifo xfer_byte_fifo_chk #(
  .DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH), .PW(PW), .CLW(CLW), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .cmd_arm(cmd_arm), .cmd_consume(cmd_consume), .cmd_active(cmd_active),
  .cmd_len(cmd_len), .phase_dout(phase_dout), .rsp_load(rsp_load),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .data_count(data_count),
  .ovf_xfer(ovf_xfer), .ovf_cmd(ovf_cmd)
);

// File: tb/xfer_byte_fifo_tb.sv
module xfer_byte_fifo_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0, rd_valid = 1'b0;
  logic       wr_ready, rd_ready, rd_data_vld;
  logic [7:0] wr_data = 8'h00, rd_data, cmd_byte;
  logic       cmd_arm = 1'b0, cmd_consume = 1'b0, cmd_active;
  logic [4:0] cmd_len;
  logic [3:0] cmd_idx = 4'd0;
  logic       phase_dout = 1'b0, rsp_load = 1'b0;
  logic [7:0] rsp_status = 8'h00;
  logic [3:0] wr_ptr, rd_ptr;
  logic [5:0] data_count;
  logic       ovf_xfer, ovf_cmd;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  xfer_byte_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_data_vld(rd_data_vld), .cmd_arm(cmd_arm),
    .cmd_consume(cmd_consume), .cmd_active(cmd_active), .cmd_len(cmd_len),
    .cmd_idx(cmd_idx), .cmd_byte(cmd_byte), .phase_dout(phase_dout),
    .rsp_load(rsp_load), .rsp_status(rsp_status), .wr_ptr(wr_ptr),
    .rd_ptr(rd_ptr), .data_count(data_count), .ovf_xfer(ovf_xfer),
    .ovf_cmd(ovf_cmd)
  );

  // op: 0 write, 1 read, 2 read in data-out phase
  // fields: {op, wdata, exp rd_data, exp wr_ptr, exp rd_ptr, exp count}
  localparam logic [41:0] VEC [8] = '{
    {2'd0, 8'h11, 8'h00, 8'd1, 8'd0, 8'd1},
    {2'd0, 8'h22, 8'h00, 8'd2, 8'd0, 8'd2},
    {2'd1, 8'h00, 8'h11, 8'd2, 8'd1, 8'd1},
    {2'd2, 8'h00, 8'h00, 8'd2, 8'd1, 8'd1},
    {2'd1, 8'h00, 8'h22, 8'd0, 8'd0, 8'd0},
    {2'd1, 8'h00, 8'h22, 8'd0, 8'd0, 8'd0},
    {2'd0, 8'h33, 8'h22, 8'd1, 8'd0, 8'd1},
    {2'd1, 8'h00, 8'h33, 8'd0, 8'd0, 8'd0}
  };

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int cnt_i();
    return int'($signed(data_count));
  endfunction

  task automatic do_wr(input logic [7:0] d);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_rd(input logic dout);
    rd_valid = 1'b1; phase_dout = dout;
    @(negedge clk);
    rd_valid = 1'b0; phase_dout = 1'b0;
  endtask

  task automatic pulse_arm();
    cmd_arm = 1'b1; @(negedge clk); cmd_arm = 1'b0;
  endtask

  task automatic pulse_consume();
    cmd_consume = 1'b1; @(negedge clk); cmd_consume = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 wr_ptr", int'(wr_ptr), 0);
    chk("R1 rd_ptr", int'(rd_ptr), 0);
    chk("R1 count", cnt_i(), 0);
    chk("R1 cmd_len", int'(cmd_len), 0);
    chk("R1 cmd_active", int'(cmd_active), 0);
    chk("R1 rd_data", int'(rd_data), 0);
    chk("R1 flags", int'({rd_data_vld, ovf_xfer, ovf_cmd}), 0);

    // table walk: R4 R5 R6 R7
    for (int i = 0; i < 8; i++) begin
      logic [41:0] v;
      v = VEC[i];
      case (v[41:40])
        2'd0: do_wr(v[39:32]);
        2'd1: do_rd(1'b0);
        default: do_rd(1'b1);
      endcase
      chk($sformatf("R4/R5/R6/R7 vec%0d rd_data", i), int'(rd_data), int'(v[31:24]));
      chk($sformatf("R4/R5 vec%0d wr_ptr", i), int'(wr_ptr), int'(v[23:16]));
      chk($sformatf("R4/R5 vec%0d rd_ptr", i), int'(rd_ptr), int'(v[15:8]));
      chk($sformatf("R4/R6 vec%0d count", i), cnt_i(), int'($signed(v[7:0])));
    end

    // R2 handshake gating, inside one low clock phase
    rsp_load = 1'b1; #1;
    chk("R2 wr_ready under rsp_load", int'(wr_ready), 0);
    chk("R2 rd_ready under rsp_load", int'(rd_ready), 0);
    rsp_load = 1'b0; wr_valid = 1'b1; #1;
    chk("R2 rd_ready under write", int'(rd_ready), 0);
    chk("R2 wr_ready idle", int'(wr_ready), 1);
    wr_valid = 1'b0; #1;
    chk("R2 rd_ready idle", int'(rd_ready), 1);
    @(negedge clk);

    // R3 fill to DEPTH-1 then overrun
    for (int i = 0; i < 15; i++) do_wr(8'h40 + 8'(i));
    chk("R3 wr_ptr full", int'(wr_ptr), 15);
    chk("R3 count full", cnt_i(), 15);
    chk("R3 no early ovf", int'(ovf_xfer), 0);
    do_wr(8'hEE);
    chk("R3 ovf_xfer pulse", int'(ovf_xfer), 1);
    chk("R3 wr_ptr held", int'(wr_ptr), 15);
    chk("R3 count held", cnt_i(), 15);
    @(negedge clk);
    chk("R3 ovf_xfer one cycle", int'(ovf_xfer), 0);

    // R4 order, R5 rewind on drain
    for (int i = 0; i < 15; i++) begin
      do_rd(1'b0);
      chk("R4 pop order", int'(rd_data), 8'h40 + i);
      chk("R4 rd_data_vld", int'(rd_data_vld), 1);
    end
    chk("R5 wr_ptr rewound", int'(wr_ptr), 0);
    chk("R5 rd_ptr rewound", int'(rd_ptr), 0);
    chk("R4 count drained", cnt_i(), 0);
    @(negedge clk);
    chk("R4 rd_data_vld drops", int'(rd_data_vld), 0);

    // R10 arm clears transfer state
    do_wr(8'h01); do_wr(8'h02);
    pulse_arm();
    chk("R10 cmd_active set", int'(cmd_active), 1);
    chk("R10 cmd_len cleared", int'(cmd_len), 0);
    chk("R10 wr_ptr cleared", int'(wr_ptr), 0);
    chk("R10 count cleared", cnt_i(), 0);

    // R8 command capture
    do_wr(8'hC0); do_wr(8'hC1); do_wr(8'hC2);
    chk("R8 cmd_len", int'(cmd_len), 3);
    chk("R8 wr_ptr untouched", int'(wr_ptr), 0);
    chk("R8 count untouched", cnt_i(), 0);
    cmd_idx = 4'd1; #1;
    chk("R8 cmd_byte idx1", int'(cmd_byte), 8'hC1);
    cmd_idx = 4'd2; #1;
    chk("R8 cmd_byte idx2", int'(cmd_byte), 8'hC2);

    // R9 command overrun
    for (int i = 3; i < 16; i++) do_wr(8'hC0 + 8'(i));
    chk("R9 cmd_len full", int'(cmd_len), 16);
    chk("R9 no early ovf", int'(ovf_cmd), 0);
    do_wr(8'hFF);
    chk("R9 ovf_cmd pulse", int'(ovf_cmd), 1);
    chk("R9 cmd_len held", int'(cmd_len), 16);
    cmd_idx = 4'd15; #1;
    chk("R9 last kept byte", int'(cmd_byte), 8'hCF);
    @(negedge clk);
    chk("R9 ovf_cmd one cycle", int'(ovf_cmd), 0);

    // R10 consume
    pulse_consume();
    chk("R10 cmd_active cleared", int'(cmd_active), 0);
    chk("R10 cmd_len after consume", int'(cmd_len), 0);
    chk("R10 count after consume", cnt_i(), 0);

    // R11 response load over pending data
    do_wr(8'h77);
    rsp_status = 8'hA5; rsp_load = 1'b1;
    @(negedge clk);
    rsp_load = 1'b0;
    chk("R11 wr_ptr", int'(wr_ptr), 2);
    chk("R11 rd_ptr", int'(rd_ptr), 0);
    chk("R11 count", cnt_i(), 2);
    do_rd(1'b0);
    chk("R11 status byte", int'(rd_data), 8'hA5);
    do_rd(1'b0);
    chk("R11 tail byte", int'(rd_data), 8'h00);
    chk("R11 drained wr_ptr", int'(wr_ptr), 0);
    chk("R11 drained count", cnt_i(), 0);

    // R7 empty read after a non-zero pop
    do_wr(8'h5A); do_rd(1'b0); do_rd(1'b0);
    chk("R7 empty read holds", int'(rd_data), 8'h5A);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule